// File: doc/BRIEF.md
# Synchronous Trap Entry Register Updater

This block computes and holds the architectural state a core changes when it accepts one of two synchronous traps. One is a software-requested system call. The other is an attempt to use floating-point hardware while that hardware is switched off. The core arbitrates priority elsewhere and hands the winning request to this block with a one-cycle take strobe and a kind bit. In that same clock edge the block commits four things: the return address, the saved machine state, the reduced machine state, and the fetch target vector. A system call also writes the trap syndrome.

The block holds a vector prefix register and two per-kind offset registers, which software loads through a small write port. A return input brings the saved machine state back into the live machine-state output, and the saved return address is always visible as the resume address.

Machine-state bit layout (LSB = bit 0): 0 data space, 1 instruction space, 2 FP exception mode 1, 3 FP exception mode 0, 4 FP enable, 5 user mode, 6 external interrupt enable, 7 wait enable, 8 vector unit enable, 9 user cache lock, 10 critical enable, 11 machine check enable, 12 debug enable, 13 recoverable flag, 14..31 other.

Top module: `exc_entry_unit`

## Requirements
- R1: After reset, `srr0_o`, `srr1_o`, `msr_o`, `esr_o` and `vector_o` are all zero, and all three vector registers are zero.
- R2: On a take with `kind_i`=1 (system call), `srr0_o` becomes `pc_next_i`. With `kind_i`=0 (FP unavailable) it becomes `pc_cur_i`. The new value is visible after the edge on which `take_i` is sampled high.
- R3: On any take, `srr1_o` becomes the full `msr_i`.
- R4: On any take, `msr_o` becomes `msr_i` with bits 0-5 and 7-9 cleared and every other bit kept. A system call also clears bit 6, while FP unavailable keeps bit 6 (clear mask 0x3FF vs 0x3BF).
- R5: A system call sets `esr_o` to zero except bit 5, which takes the value of `vle_i`. An FP-unavailable take leaves `esr_o` unchanged.
- R6: On a take, `vector_o` becomes {prefix[31:16], offset[15:4], 4'b0000}. The offset is the FP offset for `kind_i`=0 and the system-call offset for `kind_i`=1. A write with `cfg_addr_i` 0 loads the prefix, 1 loads the FP offset and 2 loads the system-call offset.
- R7: With `take_i` and `rfi_i` both low, all outputs hold their values whatever the other inputs do.
- R8: `rfi_i` high without a take copies `srr1_o` into `msr_o` and leaves `srr0_o`, `srr1_o`, `esr_o` and `vector_o` unchanged. `resume_o` always equals `srr0_o`.
- R9: When `take_i` and `rfi_i` are both high, the take is performed and the return is dropped.
- R10: A take reads the vector registers as they were before the edge, so a write in the same cycle affects only later takes.
- R11: A write with `cfg_addr_i` 3 changes no vector register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| take_i | input | 1 | Accept a trap this cycle |
| kind_i | input | 1 | 1 = system call, 0 = FP unavailable |
| pc_cur_i | input | 32 | Address of the trapping instruction |
| pc_next_i | input | 32 | Address of the following instruction |
| msr_i | input | 32 | Machine state before the trap |
| vle_i | input | 1 | System call came from the variable-length encoding |
| rfi_i | input | 1 | Return from trap |
| cfg_we_i | input | 1 | Vector register write enable |
| cfg_addr_i | input | 2 | Vector register select |
| cfg_wdata_i | input | 32 | Vector register write data |
| srr0_o | output | 32 | Saved return address |
| srr1_o | output | 32 | Saved machine state |
| msr_o | output | 32 | Machine state to install |
| esr_o | output | 32 | Trap syndrome |
| vector_o | output | 32 | Fetch target after entry |
| resume_o | output | 32 | Address to resume at on return |

## Verification
The bound checker checks several rules on every cycle: the choice of return address per kind, the capture of the old machine state, the cleared-bit masks, the syndrome shape, the alignment of the vector, the holding when idle, and the restore on return. Only the bench scenarios can show that particular vector values come from the right register and field. They also show that a same-cycle write reaches only the next take, that address 3 writes are ignored, and that a take overrides a simultaneous return.

// File: rtl/exc_entry_unit.sv
module exc_entry_unit #(
  parameter int AW      = 32,
  parameter int SW      = 32,
  parameter int VLE_BIT = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take_i,
  input  logic          kind_i,
  input  logic [AW-1:0] pc_cur_i,
  input  logic [AW-1:0] pc_next_i,
  input  logic [SW-1:0] msr_i,
  input  logic          vle_i,
  input  logic          rfi_i,
  input  logic          cfg_we_i,
  input  logic [1:0]    cfg_addr_i,
  input  logic [AW-1:0] cfg_wdata_i,
  output logic [AW-1:0] srr0_o,
  output logic [SW-1:0] srr1_o,
  output logic [SW-1:0] msr_o,
  output logic [SW-1:0] esr_o,
  output logic [AW-1:0] vector_o,
  output logic [AW-1:0] resume_o
);
  localparam int PH    = AW / 2;
  localparam int OFS_W = PH - 4;
  localparam logic [SW-1:0] CLR_FP = SW'(10'h3BF);
  localparam logic [SW-1:0] CLR_SC = SW'(10'h3FF);

  logic [PH-1:0]    pfx_q;
  logic [OFS_W-1:0] ofs_fp_q, ofs_sc_q;
  logic [OFS_W-1:0] ofs_sel;

  assign ofs_sel  = kind_i ? ofs_sc_q : ofs_fp_q;
  assign resume_o = srr0_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pfx_q    <= '0;
      ofs_fp_q <= '0;
      ofs_sc_q <= '0;
    end else if (cfg_we_i) begin
      case (cfg_addr_i)
        2'd0:    pfx_q    <= cfg_wdata_i[AW-1:PH];
        2'd1:    ofs_fp_q <= cfg_wdata_i[PH-1:4];
        2'd2:    ofs_sc_q <= cfg_wdata_i[PH-1:4];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      srr0_o   <= '0;
      srr1_o   <= '0;
      msr_o    <= '0;
      esr_o    <= '0;
      vector_o <= '0;
    end else if (take_i) begin
      srr0_o   <= kind_i ? pc_next_i : pc_cur_i;
      srr1_o   <= msr_i;
      msr_o    <= msr_i & ~(kind_i ? CLR_SC : CLR_FP);
      vector_o <= {pfx_q, ofs_sel, 4'b0000};
      if (kind_i)
        esr_o <= SW'(vle_i) << VLE_BIT;
    end else if (rfi_i) begin
      msr_o <= srr1_o;
    end
  end
endmodule

module exc_entry_unit_chk #(
  parameter int AW      = 32,
  parameter int SW      = 32,
  parameter int VLE_BIT = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          take_i,
  input logic          kind_i,
  input logic [AW-1:0] pc_cur_i,
  input logic [AW-1:0] pc_next_i,
  input logic [SW-1:0] msr_i,
  input logic          vle_i,
  input logic          rfi_i,
  input logic [SW-1:0] srr0_o,
  input logic [SW-1:0] srr1_o,
  input logic [SW-1:0] msr_o,
  input logic [SW-1:0] esr_o,
  input logic [AW-1:0] vector_o
);
  localparam logic [SW-1:0] KEEP_ESR = SW'(1) << VLE_BIT;

  p_srr0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> srr0_o == ($past(kind_i) ? $past(pc_next_i) : $past(pc_cur_i)));

  p_srr1_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> srr1_o == $past(msr_i));

  p_msr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> (msr_o[9:0] & 10'h3BF) == 10'h0 && msr_o[SW-1:10] == $past(msr_i[SW-1:10])
               && msr_o[6] == ($past(kind_i) ? 1'b0 : $past(msr_i[6])));

  p_esr_sc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take_i && kind_i |=> (esr_o & ~KEEP_ESR) == '0 && esr_o[VLE_BIT] == $past(vle_i));

  p_esr_fp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take_i && !kind_i |=> $stable(esr_o));

  p_vec_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vector_o[3:0] == 4'h0);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !take_i && !rfi_i |=> $stable(srr0_o) && $stable(srr1_o) && $stable(msr_o)
                         && $stable(esr_o) && $stable(vector_o));

  p_rfi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rfi_i && !take_i |=> msr_o == $past(srr1_o) && $stable(srr0_o) && $stable(vector_o));
endmodule

bind exc_entry_unit exc_entry_unit_chk #(.AW(AW), .SW(SW), .VLE_BIT(VLE_BIT)) u_chk (.*);

// File: tb/tb_exc_entry_unit.sv
module tb_exc_entry_unit;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        take_i = 0, kind_i = 0, vle_i = 0, rfi_i = 0, cfg_we_i = 0;
  logic [1:0]  cfg_addr_i = 0;
  logic [31:0] pc_cur_i = 0, pc_next_i = 0, msr_i = 0, cfg_wdata_i = 0;
  logic [31:0] srr0_o, srr1_o, msr_o, esr_o, vector_o, resume_o;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  exc_entry_unit dut (.*);

  function automatic logic [31:0] mkvec(input logic [31:0] p, input logic [31:0] o);
    return {p[31:16], o[15:4], 4'h0};
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we_i = 1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk);
    cfg_we_i = 0;
  endtask

  task automatic take(input logic k, input logic [31:0] pc, input logic [31:0] pn,
                      input logic [31:0] m, input logic v);
    @(negedge clk);
    take_i = 1; kind_i = k; pc_cur_i = pc; pc_next_i = pn; msr_i = m; vle_i = v;
    @(negedge clk);
    take_i = 0;
  endtask

  localparam logic [31:0] PFX = 32'hABCD_1234, OFP = 32'h0000_0567, OSC = 32'hFFFF_FFF9;

  task automatic t_reset;
    chk("R1 srr0", srr0_o, 0);   chk("R1 srr1", srr1_o, 0);
    chk("R1 msr", msr_o, 0);     chk("R1 esr", esr_o, 0);
    chk("R1 vector", vector_o, 0);
    take(1'b1, 32'h10, 32'h14, 32'h0, 1'b0);
    chk("R1 vector regs zero", vector_o, 0);
  endtask

  task automatic t_syscall;
    cfg(2'd0, PFX); cfg(2'd1, OFP); cfg(2'd2, OSC);
    take(1'b1, 32'h1000, 32'h1004, 32'hFFFF_FFFF, 1'b1);
    chk("R2 sc srr0", srr0_o, 32'h1004);
    chk("R3 sc srr1", srr1_o, 32'hFFFF_FFFF);
    chk("R4 sc msr", msr_o, 32'hFFFF_FC00);
    chk("R5 sc esr vle", esr_o, 32'h20);
    chk("R6 sc vector", vector_o, mkvec(PFX, OSC));
  endtask

  task automatic t_fpu;
    take(1'b0, 32'h2000, 32'h2002, 32'h0000_3FFF, 1'b1);
    chk("R2 fp srr0", srr0_o, 32'h2000);
    chk("R3 fp srr1", srr1_o, 32'h3FFF);
    chk("R4 fp msr", msr_o, 32'h3C40);
    chk("R5 fp esr kept", esr_o, 32'h20);
    chk("R6 fp vector", vector_o, mkvec(PFX, OFP));
  endtask

  task automatic t_syscall_novle;
    take(1'b1, 32'h3000, 32'h3004, 32'h0000_0040, 1'b0);
    chk("R5 sc esr clear", esr_o, 0);
    chk("R4 sc ee clear", msr_o, 0);
  endtask

  task automatic t_hold;
    @(negedge clk);
    pc_cur_i = 32'h5555; pc_next_i = 32'h6666; msr_i = 32'h1234_5678; kind_i = 0; vle_i = 1;
    repeat (3) @(negedge clk);
    chk("R7 srr0 hold", srr0_o, 32'h3004);
    chk("R7 srr1 hold", srr1_o, 32'h40);
    chk("R7 msr hold", msr_o, 0);
    chk("R7 esr hold", esr_o, 0);
    chk("R7 vector hold", vector_o, mkvec(PFX, OSC));
  endtask

  task automatic t_rfi;
    take(1'b0, 32'h4000, 32'h4004, 32'hFFFF_0F0F, 1'b0);
    @(negedge clk);
    rfi_i = 1;
    @(negedge clk);
    rfi_i = 0;
    chk("R8 rfi msr", msr_o, 32'hFFFF_0F0F);
    chk("R8 rfi srr0 kept", srr0_o, 32'h4000);
    chk("R8 resume", resume_o, 32'h4000);
    chk("R8 rfi vector kept", vector_o, mkvec(PFX, OFP));
  endtask

  task automatic t_take_over_rfi;
    @(negedge clk);
    take_i = 1; rfi_i = 1; kind_i = 1; pc_cur_i = 32'h7000; pc_next_i = 32'h7004;
    msr_i = 32'h0000_FFFF; vle_i = 0;
    @(negedge clk);
    take_i = 0; rfi_i = 0;
    chk("R9 take wins msr", msr_o, 32'h0000_FC00);
    chk("R9 take wins srr0", srr0_o, 32'h7004);
  endtask

  task automatic t_cfg_same_cycle;
    @(negedge clk);
    cfg_we_i = 1; cfg_addr_i = 2'd2; cfg_wdata_i = 32'h0000_1230;
    take_i = 1; kind_i = 1; pc_cur_i = 32'h8000; pc_next_i = 32'h8004; msr_i = 0;
    @(negedge clk);
    cfg_we_i = 0; take_i = 0;
    chk("R10 old offset used", vector_o, mkvec(PFX, OSC));
    take(1'b1, 32'h8100, 32'h8104, 32'h0, 1'b0);
    chk("R10 new offset next", vector_o, mkvec(PFX, 32'h0000_1230));
  endtask

  task automatic t_addr3;
    cfg(2'd3, 32'h1111_1111);
    take(1'b1, 32'h9000, 32'h9004, 32'h0, 1'b0);
    chk("R11 sc vector unchanged", vector_o, mkvec(PFX, 32'h0000_1230));
    take(1'b0, 32'h9100, 32'h9104, 32'h0, 1'b0);
    chk("R11 fp vector unchanged", vector_o, mkvec(PFX, OFP));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_syscall;
    t_fpu;
    t_syscall_novle;
    t_hold;
    t_rfi;
    t_take_over_rfi;
    t_cfg_same_cycle;
    t_addr3;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule